// File: doc/BRIEF.md
# Output Compare Pin Action Unit

This block is the output side of an eight-channel timer. A free-running counter comes in from outside. Each channel holds its own compare value. When the counter equals that value, the channel raises its flag and applies its programmed pin action to its port bit. The action can leave the pin alone, toggle it, drive it low or drive it high. Software can also fire any channel at once by writing its bit to a strobe address. A fired channel takes the same pin action as a real match but leaves its flag alone.

Channel 7 acts as a master. Each port bit can be claimed by a master mask. Whenever channel 7 fires, every claimed bit is loaded from a master data register. A claimed bit ignores its own channel's action. A claimed bit also becomes an output when its channel is marked as output compare, whatever its direction bit says.

Each port bit has a per-pin action state that is chosen fresh on every cycle. The states are HOLD, TOGGLE, LOW, HIGH and MASTER. MASTER is chosen when the bit is claimed and channel 7 fires. HOLD is chosen when the bit is claimed and channel 7 is idle. Otherwise the state comes from the channel's mode field when the channel fires, and is HOLD when it does not fire.

Top module: `oc_unit`

## Requirements
- R1: After reset, every pin, output enable, flag and register reads as zero.
- R2: In a cycle where `cnt_in` equals a channel's compare value (address n for channel n), the channel's flag reads 1 after that clock edge.
- R3: Writing to the flag address (14) clears each flag whose data bit is 1. A 0 bit leaves its flag unchanged. A new match in the same cycle keeps the flag set.
- R4: The mode field of channel n sits at bits [2n+1:2n] of the mode register (address 8). When the channel fires, 00 leaves the pin unchanged, 01 inverts it, 10 drives it to 0 and 11 drives it to 1. The new level is visible after the firing edge.
- R5: Writing a 1 in bit n at the strobe address (11) fires channel n at that edge, exactly as a match would. A strobe alone never sets a flag.
- R6: Reading the strobe address always returns 0.
- R7: If a strobe and a match hit one channel in the same cycle, the action is applied once (a toggle inverts the pin once) and the flag is set.
- R8: `pin_oe` bit n is 1 when direction bit n (address 10) is 1, or when mask bit n (address 12) and output-compare select bit n (address 9) are both 1. The direction register keeps the value written.
- R9: When channel 7 fires, by match or by strobe, each pin whose mask bit is 1 takes the matching bit of the master data register (address 13). A strobe on channel 7 sets no flag.
- R10: A pin whose mask bit is 1 does not change on its own channel's firing.
- R11: When channel 7 fires in the same cycle as another channel whose pin is masked, the pin takes the master data bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_in | input | 16 | Free-running counter value |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write enable for this cycle |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| pin_out | output | 8 | Port pin levels |
| pin_oe | output | 8 | Port output enables |
| flag_out | output | 8 | Channel match flags |

## Verification
Two kinds of collision can fall in one cycle.

The first is a strobe write on a channel together with a real match on the same channel. The bench sets the compare value equal to the counter value it drives during the strobe write. It then checks that a toggling pin moved only once and that the flag rose.

The second is a channel-7 match together with a match on another channel whose pin is masked. The bench gives both channels the same compare value, with the other channel set to drive its pin high and the master data driving it low. It judges that the pin ends low and that both flags are set.

A behavioural model follows every cycle of a long random run. That run also hits both collisions at random.

// File: rtl/oc_pkg.sv
package oc_pkg;

    // register offsets above the block of compare registers
    localparam int OFS_MODE  = 0;
    localparam int OFS_SEL   = 1;
    localparam int OFS_DIR   = 2;
    localparam int OFS_STRB  = 3;
    localparam int OFS_MASK  = 4;
    localparam int OFS_MDATA = 5;
    localparam int OFS_FLAG  = 6;

    // per-pin action chosen each cycle
    typedef enum logic [2:0] {
        ACT_HOLD,
        ACT_TOGGLE,
        ACT_LOW,
        ACT_HIGH,
        ACT_MASTER
    } pin_act_e;

endpackage

// File: rtl/oc_regbank.sv
module oc_regbank
    import oc_pkg::*;
#(
    parameter int NCH = 8,
    parameter int CW  = 16,
    parameter int AW  = 4,
    parameter int DW  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           bus_addr,
    input  logic [DW-1:0]           bus_wdata,
    input  logic                    bus_we,
    input  logic [NCH-1:0]          flags,
    output logic [DW-1:0]           bus_rdata,
    output logic [NCH-1:0][CW-1:0]  cmp_q,
    output logic [2*NCH-1:0]        mode_q,
    output logic [NCH-1:0]          sel_q,
    output logic [NCH-1:0]          dir_q,
    output logic [NCH-1:0]          mask_q,
    output logic [NCH-1:0]          mdata_q,
    output logic [NCH-1:0]          strobe_v,
    output logic [NCH-1:0]          flag_clr
);

    localparam logic [AW-1:0] A_MODE  = AW'(NCH + OFS_MODE);
    localparam logic [AW-1:0] A_SEL   = AW'(NCH + OFS_SEL);
    localparam logic [AW-1:0] A_DIR   = AW'(NCH + OFS_DIR);
    localparam logic [AW-1:0] A_STRB  = AW'(NCH + OFS_STRB);
    localparam logic [AW-1:0] A_MASK  = AW'(NCH + OFS_MASK);
    localparam logic [AW-1:0] A_MDATA = AW'(NCH + OFS_MDATA);
    localparam logic [AW-1:0] A_FLAG  = AW'(NCH + OFS_FLAG);

    for (genvar i = 0; i < NCH; i++) begin : g_cmp
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cmp_q[i] <= '0;
            end else if (bus_we && bus_addr == AW'(i)) begin
                cmp_q[i] <= bus_wdata[CW-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= '0;
            sel_q   <= '0;
            dir_q   <= '0;
            mask_q  <= '0;
            mdata_q <= '0;
        end else if (bus_we) begin
            if (bus_addr == A_MODE)  mode_q  <= bus_wdata[2*NCH-1:0];
            if (bus_addr == A_SEL)   sel_q   <= bus_wdata[NCH-1:0];
            if (bus_addr == A_DIR)   dir_q   <= bus_wdata[NCH-1:0];
            if (bus_addr == A_MASK)  mask_q  <= bus_wdata[NCH-1:0];
            if (bus_addr == A_MDATA) mdata_q <= bus_wdata[NCH-1:0];
        end
    end

    // one-cycle strobes, never stored
    assign strobe_v = (bus_we && bus_addr == A_STRB) ? bus_wdata[NCH-1:0] : '0;
    assign flag_clr = (bus_we && bus_addr == A_FLAG) ? bus_wdata[NCH-1:0] : '0;

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (bus_addr == AW'(i)) bus_rdata = DW'(cmp_q[i]);
        end
        if (bus_addr == A_MODE)  bus_rdata = DW'(mode_q);
        if (bus_addr == A_SEL)   bus_rdata = DW'(sel_q);
        if (bus_addr == A_DIR)   bus_rdata = DW'(dir_q);
        if (bus_addr == A_MASK)  bus_rdata = DW'(mask_q);
        if (bus_addr == A_MDATA) bus_rdata = DW'(mdata_q);
        if (bus_addr == A_FLAG)  bus_rdata = DW'(flags);
    end

endmodule

// File: rtl/oc_chan.sv
module oc_chan #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] cmp,
    input  logic          clr,
    output logic          match,
    output logic          flag
);

    assign match = (cnt == cmp);

    // a match outranks a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (match) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/oc_pin.sv
module oc_pin
    import oc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fire,
    input  logic [1:0] mode,
    input  logic       mask,
    input  logic       master_fire,
    input  logic       master_bit,
    output logic       pin
);

    pin_act_e act;

    always_comb begin
        if (mask) begin
            act = master_fire ? ACT_MASTER : ACT_HOLD;
        end else if (fire) begin
            unique case (mode)
                2'b00:   act = ACT_HOLD;
                2'b01:   act = ACT_TOGGLE;
                2'b10:   act = ACT_LOW;
                default: act = ACT_HIGH;
            endcase
        end else begin
            act = ACT_HOLD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin <= 1'b0;
        end else begin
            unique case (act)
                ACT_HOLD:   pin <= pin;
                ACT_TOGGLE: pin <= ~pin;
                ACT_LOW:    pin <= 1'b0;
                ACT_HIGH:   pin <= 1'b1;
                ACT_MASTER: pin <= master_bit;
                default:    pin <= pin;
            endcase
        end
    end

endmodule

// File: rtl/oc_unit.sv
module oc_unit #(
    parameter int NCH = 8,
    parameter int CW  = 16,
    parameter int AW  = 4,
    parameter int DW  = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [CW-1:0]  cnt_in,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    input  logic           bus_we,
    output logic [DW-1:0]  bus_rdata,
    output logic [NCH-1:0] pin_out,
    output logic [NCH-1:0] pin_oe,
    output logic [NCH-1:0] flag_out
);

    logic [NCH-1:0][CW-1:0] cmp_q;
    logic [2*NCH-1:0]       mode_q;
    logic [NCH-1:0]         sel_q;
    logic [NCH-1:0]         dir_q;
    logic [NCH-1:0]         mask_q;
    logic [NCH-1:0]         mdata_q;
    logic [NCH-1:0]         strobe_v;
    logic [NCH-1:0]         flag_clr;
    logic [NCH-1:0]         match_v;
    logic [NCH-1:0]         fire_v;
    logic                   fire7;

    oc_regbank #(.NCH(NCH), .CW(CW), .AW(AW), .DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .flags     (flag_out),
        .bus_rdata (bus_rdata),
        .cmp_q     (cmp_q),
        .mode_q    (mode_q),
        .sel_q     (sel_q),
        .dir_q     (dir_q),
        .mask_q    (mask_q),
        .mdata_q   (mdata_q),
        .strobe_v  (strobe_v),
        .flag_clr  (flag_clr)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        oc_chan #(.CW(CW)) u_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .cnt   (cnt_in),
            .cmp   (cmp_q[i]),
            .clr   (flag_clr[i]),
            .match (match_v[i]),
            .flag  (flag_out[i])
        );
    end

    assign fire_v = match_v | strobe_v;
    assign fire7  = fire_v[NCH-1];

    for (genvar i = 0; i < NCH; i++) begin : g_pin
        oc_pin u_pin (
            .clk         (clk),
            .rst_n       (rst_n),
            .fire        (fire_v[i]),
            .mode        (mode_q[2*i+1:2*i]),
            .mask        (mask_q[i]),
            .master_fire (fire7),
            .master_bit  (mdata_q[i]),
            .pin         (pin_out[i])
        );
    end

    assign pin_oe = dir_q | (mask_q & sel_q);

endmodule

// File: rtl/oc_chk.sv
module oc_chk #(
    parameter int NCH = 8,
    parameter int AW  = 4,
    parameter int DW  = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic [AW-1:0]  bus_addr,
    input logic [DW-1:0]  bus_rdata,
    input logic [NCH-1:0] match_v,
    input logic [NCH-1:0] strobe_v,
    input logic [NCH-1:0] flag_clr,
    input logic [NCH-1:0] flag_out,
    input logic [NCH-1:0] mask_q,
    input logic [NCH-1:0] mdata_q,
    input logic [NCH-1:0] sel_q,
    input logic           fire7,
    input logic [NCH-1:0] pin_out,
    input logic [NCH-1:0] pin_oe
);

    localparam logic [AW-1:0] A_STRB = AW'(NCH + oc_pkg::OFS_STRB);

    assert_match_sets_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (match_v != '0) |=> ((flag_out & $past(match_v)) == $past(match_v)));

    assert_clear_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_clr & ~match_v & flag_out) != '0) |=> ((flag_out & $past(flag_clr & ~match_v)) == '0));

    assert_strobe_no_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((strobe_v & ~match_v & ~flag_out) != '0) |=> ((flag_out & $past(strobe_v & ~match_v & ~flag_out)) == '0));

    assert_strobe_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_STRB) |-> (bus_rdata == '0));

    assert_mask_forces_oe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((mask_q & sel_q & ~pin_oe) == '0));

    assert_master_loads_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fire7 |=> (((pin_out ^ $past(mdata_q)) & $past(mask_q)) == '0));

    assert_mask_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !fire7 |=> (((pin_out ^ $past(pin_out)) & $past(mask_q)) == '0));

    assert_master_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (fire7 && ((match_v | strobe_v) & mask_q) != '0)
            |=> (((pin_out ^ $past(mdata_q)) & $past(mask_q)) == '0));

endmodule

bind oc_unit oc_chk #(.NCH(NCH), .AW(AW), .DW(DW)) u_oc_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .match_v   (match_v),
    .strobe_v  (strobe_v),
    .flag_clr  (flag_clr),
    .flag_out  (flag_out),
    .mask_q    (mask_q),
    .mdata_q   (mdata_q),
    .sel_q     (sel_q),
    .fire7     (fire7),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/test_oc_unit.sv
module test_oc_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt = 16'h1111;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic        we = 1'b0;
    logic [15:0] rdata;
    logic [7:0]  pin_out, pin_oe, flag_out;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    oc_unit i_oc_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_in    (cnt),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_we    (we),
        .bus_rdata (rdata),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .flag_out  (flag_out)
    );

    // ---------------- behavioural reference model ----------------
    int       m_cmp [8];
    int       m_mode, m_sel, m_dir, m_mask, m_mdata, m_flag, m_pin;
    bit       m_live = 0;

    function automatic int m_read(int a);
        if (a < 8) return m_cmp[a];
        case (a)
            8:  return m_mode;
            9:  return m_sel;
            10: return m_dir;
            12: return m_mask;
            13: return m_mdata;
            14: return m_flag;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_cmp[k]) m_cmp[k] = 0;
            m_mode = 0; m_sel = 0; m_dir = 0; m_mask = 0;
            m_mdata = 0; m_flag = 0; m_pin = 0;
            m_live = 1;
        end else begin
            int hits, strb, fires, clr, nxt;
            hits = 0;
            for (int k = 0; k < 8; k++)
                if (int'(cnt) == m_cmp[k]) hits |= (1 << k);
            strb  = (we && addr == 11) ? int'(wdata[7:0]) : 0;
            clr   = (we && addr == 14) ? int'(wdata[7:0]) : 0;
            fires = hits | strb;
            nxt   = m_pin;
            for (int k = 0; k < 8; k++) begin
                if ((m_mask >> k) & 1) begin
                    if ((fires >> 7) & 1)
                        nxt = (nxt & ~(1 << k)) | (m_mdata & (1 << k));
                end else if ((fires >> k) & 1) begin
                    case ((m_mode >> (2 * k)) & 3)
                        1: nxt ^= (1 << k);
                        2: nxt &= ~(1 << k);
                        3: nxt |= (1 << k);
                        default: ;
                    endcase
                end
            end
            m_pin  = nxt;
            m_flag = (m_flag & ~clr) | hits;
            if (we) begin
                if (addr < 8) m_cmp[addr] = int'(wdata);
                case (addr)
                    8:  m_mode  = int'(wdata);
                    9:  m_sel   = int'(wdata[7:0]);
                    10: m_dir   = int'(wdata[7:0]);
                    12: m_mask  = int'(wdata[7:0]);
                    13: m_mdata = int'(wdata[7:0]);
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // compare against the model on every clock, away from the edge
    always @(negedge clk) begin
        if (rst_n && m_live && !done) begin
            chk("R4 model pins", int'(pin_out), m_pin);
            chk("R2 model flags", int'(flag_out), m_flag);
            chk("R8 model oe", int'(pin_oe), m_dir | (m_mask & m_sel));
            #1 chk("R6 model read", int'(rdata), m_read(int'(addr)));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(int a, int d);
        @(negedge clk);
        addr = 4'(a); wdata = 16'(d); we = 1'b1;
        @(negedge clk);
        we = 1'b0; addr = 4'd0;
    endtask

    task automatic wr_cnt(int a, int d, int c);
        @(negedge clk);
        addr = 4'(a); wdata = 16'(d); we = 1'b1; cnt = 16'(c);
        @(negedge clk);
        we = 1'b0; addr = 4'd0; cnt = 16'h1111;
    endtask

    task automatic tick_cnt(int c);
        @(negedge clk);
        cnt = 16'(c);
        @(negedge clk);
        cnt = 16'h1111;
    endtask

    task automatic rd(int a, output int v);
        @(negedge clk);
        addr = 4'(a); we = 1'b0;
        #2 v = int'(rdata);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        chk("R1 pins", int'(pin_out), 0);
        chk("R1 oe", int'(pin_oe), 0);
        chk("R1 flags", int'(flag_out), 0);
        rd(12, v); chk("R1 mask reg", v, 0);

        // R2, R4: toggle on match
        wr(0, 16'h0010);
        wr(8, 16'h0001);
        tick_cnt(16'h0010);
        chk("R4 toggle", int'(pin_out), 8'h01);
        chk("R2 flag", int'(flag_out) & 1, 1);

        // R3: write 0 keeps, write 1 clears
        wr(14, 0);
        chk("R3 keep", int'(flag_out) & 1, 1);
        wr(14, 1);
        chk("R3 clear", int'(flag_out) & 1, 0);

        // R4, R5: strobe drives low/high without flags
        wr(8, 16'h0039);
        wr(11, 8'h06);
        chk("R5 strobe pins", int'(pin_out), 8'h05);
        chk("R5 no flag", int'(flag_out), 0);
        rd(11, v); chk("R6 strobe read", v, 0);

        // R7: strobe and match on channel 0 together
        wr_cnt(11, 8'h01, 16'h0010);
        chk("R7 single toggle", int'(pin_out), 8'h04);
        chk("R7 flag", int'(flag_out) & 1, 1);
        wr(14, 8'hFF);

        // R8: output enables
        wr(10, 8'h01);
        wr(9, 8'h08);
        wr(12, 8'h38);
        chk("R8 oe", int'(pin_oe), 8'h09);
        rd(10, v); chk("R8 dir kept", v, 8'h01);

        // R10: masked pin ignores its own channel
        wr(8, 16'h00F9);
        wr(3, 16'h0020);
        tick_cnt(16'h0020);
        chk("R10 blocked", int'(pin_out), 8'h04);
        chk("R10 flag set", (int'(flag_out) >> 3) & 1, 1);

        // R9: strobe on channel 7 loads master data, no flag
        wr(13, 8'h18);
        wr(14, 8'hFF);
        wr(11, 8'h80);
        chk("R9 master load", int'(pin_out), 8'h1C);
        chk("R9 no flag", int'(flag_out), 0);

        // R11: master beats channel 2 in the same cycle
        wr(12, 8'h04);
        wr(13, 8'h00);
        wr(7, 16'h0040);
        wr(2, 16'h0040);
        tick_cnt(16'h0040);
        chk("R11 master wins", int'(pin_out), 8'h18);
        chk("R11 flags", int'(flag_out) & 8'h84, 8'h84);

        // random run checked by the model
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            cnt  = 16'($urandom_range(0, 15));
            we   = ($urandom_range(0, 2) == 0);
            addr = 4'($urandom_range(0, 14));
            wdata = (addr < 8) ? 16'($urandom_range(0, 15)) : 16'($urandom);
        end
        @(negedge clk);
        we = 1'b0;
        repeat (2) @(negedge clk);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule